// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block sits between a synchronous host port and an asynchronous 1M x 16 DRAM with extended data-out page mode. It accepts word or byte read and write requests through a valid/ready handshake. It turns each request into row strobe, per-lane column strobe, write enable and output enable waveforms on a 10-bit multiplexed address bus. The upper address half selects the row and the lower half selects the column.

A register holds the row that is currently open. A request to that row reuses it, and only the column phase runs again. A request to another row closes the open row and waits a full precharge before it activates the new one. Writes use early-write timing, so the memory never drives the data bus during a write. Reads are sampled on the clock edge at which the column strobe is released, which the extended data-out hold time allows. Each timing minimum is a parameter counted in clock cycles, and the row is closed before the longest allowed row-active time runs out. An external refresh arbiter can ask for the bus. The block then finishes its current access, closes the row and grants the bus.

Top module: `edo_dram_ctrl`

## Requirements
- R1: The row, which is request address bits [19:10], is on `dram_addr` when `dram_ras_n` falls. The column, which is bits [9:0], is on `dram_addr` when a column strobe falls. A word written at address A is stored at row A[19:10], column A[9:0].
- R2: Byte enable bit 0 drives `dram_lcas_n` (data bits 7:0) and bit 1 drives `dram_ucas_n` (data bits 15:8). A lane that is not enabled is neither strobed nor written. On a read, that lane returns zero. A request with byte enables 00 strobes no lane and a read of it returns 0.
- R3: During a read column strobe, `dram_oe_n` is low and `dram_we_n` is high. The data is captured on the edge that ends the strobe and appears with a one-cycle `rdata_valid` pulse. Read results come back in request order.
- R4: On a write, `dram_we_n` is low and `dram_dq_oe` is high one cycle before the column strobe falls. `dram_oe_n` stays high. Write data stays driven for at least one cycle after the strobe rises.
- R5: A request to the row that is already open runs only a column cycle, and `dram_ras_n` does not toggle.
- R6: A request to another row raises `dram_ras_n` and keeps it high for at least max(T_RP, T_RC - T_RAS) cycles before the new row is activated.
- R7: `dram_ras_n` stays low for at least T_RAS cycles. The first column strobe falls no sooner than T_RCD+1 cycles after `dram_ras_n` falls. A column strobe stays low for at least T_CAS cycles. No column strobe is ever low while `dram_ras_n` is high.
- R8: `dram_ras_n` is never low for more than T_RAS_MAX cycles. An open row that sees no further requests is closed by the block on its own.
- R9: While `ref_req` is high, the block finishes the access in progress, closes the row and raises `ref_gnt`. During the grant all strobes stay high and `req_ready` is low. The grant drops once `ref_req` falls, and the next access activates a row again.
- R10: After reset, all DRAM strobes and enables are inactive (high), `dram_dq_oe` is low, `ref_gnt` and `rdata_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | 20 | Word address: row in [19:10], column in [9:0] |
| req_be | input | 2 | Byte enables: bit 0 lower lane, bit 1 upper lane |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, disabled lanes zero |
| rdata_valid | output | 1 | One-cycle read-complete pulse |
| ref_req | input | 1 | Refresh arbiter requests the DRAM |
| ref_gnt | output | 1 | DRAM released to the refresh arbiter |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower-lane column strobe, active low |
| dram_ucas_n | output | 1 | Upper-lane column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_in | input | 16 | Data from the DRAM pads |
| dram_dq_out | output | 16 | Data toward the DRAM pads |
| dram_dq_oe | output | 1 | Pad output enable for write data |

## Verification
If the row register tracks the open row wrongly, either a hit re-activates the row, or a miss reuses the stale row and returns data from the wrong address. The first shows as an extra `dram_ras_n` fall within a few cycles of the request. The second shows as a wrong word at the next read. If the age counter drifts, the row stays low too long or is cut short, and this shows at the first `dram_ras_n` rise. If a lane is mis-decoded, the wrong column strobe falls at once, and the next read of that address returns corrupted bytes. A sequencer state that skips a wait shortens a measured precharge, a strobe width or the RAS-to-CAS gap on the very access where it occurs.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [3:0] {
    S_IDLE,   // row closed, strobes high
    S_ACT,    // row strobe low, row address held
    S_CSET,   // column address and write enable set up
    S_CLOW,   // column strobes low
    S_CHIGH,  // column precharge, write data held
    S_OPEN,   // row open, waiting for a request
    S_CLOSE,  // row open, waiting for minimum active time
    S_PRE,    // row precharge
    S_RGNT    // bus granted to refresh arbiter
  } seq_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_row_tracker.sv
module edo_row_tracker #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_en,
  input  logic [ROW_W-1:0] open_row,
  input  logic             close_en,
  input  logic [ROW_W-1:0] query_row,
  output logic             hit
);

  logic [ROW_W-1:0] row_q;
  logic             valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q   <= '0;
      valid_q <= 1'b0;
    end else if (open_en) begin
      row_q   <= open_row;
      valid_q <= 1'b1;
    end else if (close_en) begin
      valid_q <= 1'b0;
    end
  end

  assign hit = valid_q && (row_q == query_row);

  AST_OPEN_CLOSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(open_en && close_en)); // R6

endmodule

// File: rtl/edo_ras_guard.sv
module edo_ras_guard #(
  parameter int T_RAS     = 7,
  parameter int T_RAS_MAX = 12500,
  parameter int CLOSE_AT  = 12490,
  localparam int AW       = $clog2(T_RAS_MAX + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic ras_low,
  output logic age_ok,
  output logic expired
);

  logic [AW-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst)          age_q <= '0;
    else if (ras_low) age_q <= age_q + 1'b1;
    else              age_q <= '0;
  end

  assign age_ok  = age_q >= AW'(T_RAS - 1);
  assign expired = age_q >= AW'(CLOSE_AT);

  AST_RAS_MAX: assert property (@(posedge clk) disable iff (rst)
    ras_low |-> (age_q < AW'(T_RAS_MAX))); // R8
  AST_RAS_MIN: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_low) |-> ($past(age_q) >= AW'(T_RAS - 1))); // R7

endmodule

// File: rtl/edo_seq.sv
module edo_seq import edo_pkg::*; #(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int LANE_W = 8,
  parameter int T_RCD  = 2,
  parameter int RD_LOW = 2,
  parameter int WR_LOW = 1,
  parameter int CP_CYC = 1,
  parameter int RP_CYC = 4,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int DW     = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_be,
  input  logic              req_we,
  input  logic [DW-1:0]     req_wdata,
  input  logic              hit,
  input  logic              age_ok,
  input  logic              expired,
  input  logic              ref_req,
  output logic              ref_gnt,
  output logic [DW-1:0]     rdata,
  output logic              rdata_valid,
  output logic              ras_n,
  output logic              lcas_n,
  output logic              ucas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [BUS_W-1:0]  addr_o,
  input  logic [DW-1:0]     dq_in,
  output logic [DW-1:0]     dq_out,
  output logic              dq_oe,
  output logic              open_en,
  output logic [ROW_W-1:0]  open_row,
  output logic              close_en
);

  localparam int MAXD = max2(max2(T_RCD, RD_LOW), max2(max2(WR_LOW, CP_CYC), RP_CYC));
  localparam int CW   = $clog2(MAXD + 1);

  seq_state_e state_q, nstate;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ADDR_W-1:0] r_addr, n_addr;
  logic [1:0]        r_be, n_be;
  logic              r_we, n_we;
  logic [DW-1:0]     r_wdata, n_wdata;
  logic              pend_q;
  logic              acc;
  logic              ras_lo_n, col_ph, wr_ph, rd_ph, capture;
  logic [DW-1:0]     lane_mask;

  assign req_ready = !ref_req && ((state_q == S_IDLE) || (state_q == S_OPEN && !expired));
  assign acc       = req_valid && req_ready;

  assign n_addr  = acc ? req_addr  : r_addr;
  assign n_be    = acc ? req_be    : r_be;
  assign n_we    = acc ? req_we    : r_we;
  assign n_wdata = acc ? req_wdata : r_wdata;

  always_comb begin
    nstate = state_q;
    cnt_d  = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
    case (state_q)
      S_IDLE: begin
        if (ref_req) nstate = S_RGNT;
        else if (acc) begin
          nstate = S_ACT;
          cnt_d  = CW'(T_RCD - 1);
        end
      end
      S_ACT:   if (cnt_q == '0) nstate = S_CSET;
      S_CSET: begin
        nstate = S_CLOW;
        cnt_d  = r_we ? CW'(WR_LOW - 1) : CW'(RD_LOW - 1);
      end
      S_CLOW: begin
        if (cnt_q == '0) begin
          nstate = S_CHIGH;
          cnt_d  = CW'(CP_CYC - 1);
        end
      end
      S_CHIGH: if (cnt_q == '0) nstate = S_OPEN;
      S_OPEN: begin
        if (ref_req || expired) nstate = S_CLOSE;
        else if (acc)           nstate = hit ? S_CSET : S_CLOSE;
      end
      S_CLOSE: begin
        if (age_ok) begin
          nstate = S_PRE;
          cnt_d  = CW'(RP_CYC - 1);
        end
      end
      S_PRE: begin
        if (cnt_q == '0) begin
          if (pend_q) begin
            nstate = S_ACT;
            cnt_d  = CW'(T_RCD - 1);
          end else if (ref_req) nstate = S_RGNT;
          else                  nstate = S_IDLE;
        end
      end
      S_RGNT:  if (!ref_req) nstate = S_IDLE;
      default: nstate = S_IDLE;
    endcase
  end

  assign open_en  = (nstate == S_ACT) && (state_q != S_ACT);
  assign open_row = n_addr[ADDR_W-1:COL_W];
  assign close_en = (nstate == S_PRE) && (state_q != S_PRE);

  assign ras_lo_n = (nstate == S_ACT) || (nstate == S_CSET) || (nstate == S_CLOW) ||
                    (nstate == S_CHIGH) || (nstate == S_OPEN) || (nstate == S_CLOSE);
  assign col_ph   = (nstate == S_CSET) || (nstate == S_CLOW) || (nstate == S_CHIGH);
  assign wr_ph    = col_ph && n_we;
  assign rd_ph    = ((nstate == S_CSET) || (nstate == S_CLOW)) && !n_we;
  assign capture  = (state_q == S_CLOW) && (cnt_q == '0) && !r_we;
  assign lane_mask = {{LANE_W{r_be[1]}}, {LANE_W{r_be[0]}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      cnt_q       <= '0;
      r_addr      <= '0;
      r_be        <= '0;
      r_we        <= 1'b0;
      r_wdata     <= '0;
      pend_q      <= 1'b0;
      ras_n       <= 1'b1;
      lcas_n      <= 1'b1;
      ucas_n      <= 1'b1;
      we_n        <= 1'b1;
      oe_n        <= 1'b1;
      addr_o      <= '0;
      dq_out      <= '0;
      dq_oe       <= 1'b0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
      ref_gnt     <= 1'b0;
    end else begin
      state_q <= nstate;
      cnt_q   <= cnt_d;
      if (acc) begin
        r_addr  <= req_addr;
        r_be    <= req_be;
        r_we    <= req_we;
        r_wdata <= req_wdata;
      end
      if (state_q == S_OPEN && acc && !hit) pend_q <= 1'b1;
      else if (nstate == S_ACT)             pend_q <= 1'b0;
      ras_n  <= !ras_lo_n;
      lcas_n <= !((nstate == S_CLOW) && n_be[0]);
      ucas_n <= !((nstate == S_CLOW) && n_be[1]);
      we_n   <= !wr_ph;
      oe_n   <= !rd_ph;
      dq_oe  <= wr_ph;
      if (nstate == S_CSET) dq_out <= n_wdata;
      if (nstate == S_ACT)       addr_o <= BUS_W'(n_addr[ADDR_W-1:COL_W]);
      else if (nstate == S_CSET) addr_o <= BUS_W'(n_addr[COL_W-1:0]);
      rdata_valid <= capture;
      if (capture) rdata <= dq_in & lane_mask;
      ref_gnt <= (nstate == S_RGNT);
    end
  end

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (rst)
    (!lcas_n || !ucas_n) |-> !ras_n); // R7
  AST_EARLY_WE: assert property (@(posedge clk) disable iff (rst)
    (($fell(lcas_n) || $fell(ucas_n)) && !we_n) |-> ($past(!we_n) && $past(dq_oe))); // R4
  AST_READ_OE: assert property (@(posedge clk) disable iff (rst)
    ((!lcas_n || !ucas_n) && we_n) |-> !oe_n); // R3
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rdata_valid |=> !rdata_valid); // R3
  AST_GNT_QUIET: assert property (@(posedge clk) disable iff (rst)
    ref_gnt |-> (ras_n && lcas_n && ucas_n && !req_ready)); // R9

endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl import edo_pkg::*; #(
  parameter int ROW_W     = 10,
  parameter int COL_W     = 10,
  parameter int LANE_W    = 8,
  parameter int T_RP      = 4,
  parameter int T_RAS     = 7,
  parameter int T_RC      = 11,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 1,
  parameter int T_CP      = 1,
  parameter int T_PC      = 3,
  parameter int T_CAC     = 2,
  parameter int T_RAS_MAX = 12500,
  localparam int ADDR_W   = ROW_W + COL_W,
  localparam int BUS_W    = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int DW       = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_be,
  input  logic              req_we,
  input  logic [DW-1:0]     req_wdata,
  output logic [DW-1:0]     rdata,
  output logic              rdata_valid,
  input  logic              ref_req,
  output logic              ref_gnt,
  output logic              dram_ras_n,
  output logic              dram_lcas_n,
  output logic              dram_ucas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [BUS_W-1:0]  dram_addr,
  input  logic [DW-1:0]     dram_dq_in,
  output logic [DW-1:0]     dram_dq_out,
  output logic              dram_dq_oe
);

  localparam int RD_LOW   = max2(T_CAS, T_CAC);
  localparam int WR_LOW   = T_CAS;
  localparam int CP_CYC   = max2(T_CP, T_PC - 1 - WR_LOW);
  localparam int RP_CYC   = max2(T_RP, T_RC - T_RAS);
  localparam int CLOSE_AT = T_RAS_MAX - (1 + RD_LOW + CP_CYC) - 4;

  logic             hit, age_ok, expired;
  logic             open_en, close_en;
  logic [ROW_W-1:0] open_row;

  edo_row_tracker #(.ROW_W(ROW_W)) u_rows (
    .clk       (clk),
    .rst       (rst),
    .open_en   (open_en),
    .open_row  (open_row),
    .close_en  (close_en),
    .query_row (req_addr[ADDR_W-1:COL_W]),
    .hit       (hit)
  );

  edo_ras_guard #(
    .T_RAS     (T_RAS),
    .T_RAS_MAX (T_RAS_MAX),
    .CLOSE_AT  (CLOSE_AT)
  ) u_guard (
    .clk     (clk),
    .rst     (rst),
    .ras_low (!dram_ras_n),
    .age_ok  (age_ok),
    .expired (expired)
  );

  edo_seq #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .LANE_W (LANE_W),
    .T_RCD  (T_RCD),
    .RD_LOW (RD_LOW),
    .WR_LOW (WR_LOW),
    .CP_CYC (CP_CYC),
    .RP_CYC (RP_CYC)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_be      (req_be),
    .req_we      (req_we),
    .req_wdata   (req_wdata),
    .hit         (hit),
    .age_ok      (age_ok),
    .expired     (expired),
    .ref_req     (ref_req),
    .ref_gnt     (ref_gnt),
    .rdata       (rdata),
    .rdata_valid (rdata_valid),
    .ras_n       (dram_ras_n),
    .lcas_n      (dram_lcas_n),
    .ucas_n      (dram_ucas_n),
    .we_n        (dram_we_n),
    .oe_n        (dram_oe_n),
    .addr_o      (dram_addr),
    .dq_in       (dram_dq_in),
    .dq_out      (dram_dq_out),
    .dq_oe       (dram_dq_oe),
    .open_en     (open_en),
    .open_row    (open_row),
    .close_en    (close_en)
  );

endmodule

// File: tb/edo_dram_ctrl_tb_top.sv
`timescale 1ns/1ps
module edo_dram_ctrl_tb_top;

  localparam int T_RP = 4, T_RAS = 7, T_RC = 11, T_RCD = 2, T_CAS = 1;
  localparam int T_RAS_MAX = 80;
  localparam int RP_CYC = (T_RP > T_RC - T_RAS) ? T_RP : T_RC - T_RAS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rdata_valid, ref_gnt;
  logic [15:0] rdata, dq_out, rd_word;
  logic        ras_n, lcas_n, ucas_n, we_n, oe_n, dq_oe;
  logic [9:0]  addr;

  assign rd_word_unused = 1'b0;
  logic rd_word_unused;

  edo_dram_ctrl #(.T_RAS_MAX(T_RAS_MAX)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_be(req_be), .req_we(req_we), .req_wdata(req_wdata),
    .rdata(rdata), .rdata_valid(rdata_valid), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_ras_n(ras_n), .dram_lcas_n(lcas_n), .dram_ucas_n(ucas_n),
    .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(addr),
    .dram_dq_in(rd_word), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // DRAM model and scoreboard
  logic [15:0] dmem   [int unsigned];
  logic [15:0] shadow [int unsigned];
  logic [15:0] expq[$];
  string       tagq[$];
  logic [9:0]  mrow = '0, mcol = '0;
  int act_cnt = 0, cas_fall_cnt = 0;
  int ras_low_len = 0, ras_high_len = 0, since_act = 0, cas_low_len = 0;
  bit seen_act = 0, first_cas = 0;
  logic p_ras = 1, p_l = 1, p_u = 1, p_we = 1;

  initial rd_word = '0;

  function automatic logic [15:0] peek(input logic [19:0] a);
    return dmem.exists(a) ? dmem[a] : 16'h0;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      logic fl, fu, rl, ru;
      fl = p_l && !lcas_n; fu = p_u && !ucas_n;
      rl = !p_l && lcas_n; ru = !p_u && ucas_n;
      if (p_ras && !ras_n) begin
        act_cnt++;
        mrow = addr;
        if (seen_act) chk(ras_high_len >= RP_CYC, "R6 precharge cycles", ras_high_len, RP_CYC);
        seen_act = 1; ras_low_len = 0; since_act = 0; first_cas = 1;
      end
      if (!p_ras && ras_n) begin
        chk(ras_low_len >= T_RAS, "R7 RAS low minimum", ras_low_len, T_RAS);
        chk(ras_low_len <= T_RAS_MAX, "R8 RAS low maximum", ras_low_len, T_RAS_MAX);
        ras_high_len = 0;
      end
      if (fl || fu) begin
        cas_fall_cnt++;
        mcol = addr;
        cas_low_len = 0;
        chk(!ras_n, "R7 CAS under RAS", ras_n, 0);
        if (first_cas) chk(since_act >= T_RCD + 1, "R7 RAS to CAS", since_act, T_RCD + 1);
        first_cas = 0;
        if (!we_n) begin
          logic [15:0] w;
          chk(!p_we, "R4 WE before CAS", p_we, 0);
          chk(dq_oe && oe_n, "R4 bus driven, OE high", {dq_oe, oe_n}, 2'b11);
          w = peek({mrow, addr});
          if (fl) w[7:0]  = dq_out[7:0];
          if (fu) w[15:8] = dq_out[15:8];
          dmem[{mrow, addr}] = w;
        end else begin
          chk(!oe_n, "R3 OE low on read", oe_n, 0);
        end
      end
      if ((rl || ru)) begin
        chk(cas_low_len >= T_CAS, "R7 CAS width", cas_low_len, T_CAS);
        if (!p_we) chk(dq_oe, "R4 data hold", dq_oe, 1);
      end
      if ((!lcas_n || !ucas_n) && !oe_n) rd_word = peek({mrow, mcol});
      if (rdata_valid) begin
        if (expq.size() == 0) chk(0, "R3 unexpected rdata", rdata, 0);
        else begin
          logic [15:0] e;
          string t;
          e = expq.pop_front(); t = tagq.pop_front();
          chk(rdata == e, t, rdata, e);
        end
      end
      if (!ras_n) begin ras_low_len++; since_act++; end
      else ras_high_len++;
      if (!lcas_n || !ucas_n) cas_low_len++;
      p_ras = ras_n; p_l = lcas_n; p_u = ucas_n; p_we = we_n;
    end
  end

  task automatic xfer(input logic [19:0] a, input logic [1:0] be, input bit we,
                      input logic [15:0] d, input string tag);
    logic [15:0] cur, m;
    m   = {{8{be[1]}}, {8{be[0]}}};
    cur = shadow.exists(a) ? shadow[a] : 16'h0;
    if (we) shadow[a] = (cur & ~m) | (d & m);
    else begin expq.push_back(cur & m); tagq.push_back(tag); end
    @(negedge clk);
    req_valid = 1; req_addr = a; req_be = be; req_we = we; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (2000 * 100) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int a0;
    idle(3);
    // R10 reset state
    chk(ras_n && lcas_n && ucas_n && we_n && oe_n, "R10 strobes idle",
        {ras_n, lcas_n, ucas_n, we_n, oe_n}, 5'h1f);
    chk(!dq_oe && !ref_gnt && !rdata_valid && req_ready, "R10 flags",
        {dq_oe, ref_gnt, rdata_valid, req_ready}, 4'b0001);
    rst = 0;
    idle(2);

    // R5 page hits, R1 address split
    a0 = act_cnt;
    xfer({10'h005, 10'h001}, 2'b11, 1, 16'h1234, "R5");
    xfer({10'h005, 10'h002}, 2'b11, 1, 16'h5678, "R5");
    xfer({10'h005, 10'h001}, 2'b11, 0, 16'h0, "R5 read hit 1");
    xfer({10'h005, 10'h002}, 2'b11, 0, 16'h0, "R5 read hit 2");
    idle(8);
    chk(act_cnt - a0 == 1, "R5 one activation for row hits", act_cnt - a0, 1);
    chk(peek({10'h005, 10'h001}) == 16'h1234, "R1 stored location", peek({10'h005, 10'h001}), 16'h1234);

    // R6 miss, R1 halves not swapped
    a0 = act_cnt;
    xfer({10'h003, 10'h005}, 2'b11, 1, 16'h0F0F, "R6");
    xfer({10'h005, 10'h003}, 2'b11, 1, 16'hF0F0, "R6");
    idle(10);
    chk(act_cnt - a0 == 2, "R6 activation per row change", act_cnt - a0, 2);
    chk(peek({10'h003, 10'h005}) == 16'h0F0F, "R1 row/col order", peek({10'h003, 10'h005}), 16'h0F0F);
    chk(peek({10'h005, 10'h003}) == 16'hF0F0, "R1 row/col order", peek({10'h005, 10'h003}), 16'hF0F0);
    xfer({10'h003, 10'h005}, 2'b11, 0, 16'h0, "R1 read back");

    // R2 byte lanes
    xfer({10'h2A7, 10'h100}, 2'b11, 1, 16'hA1B2, "R2");
    xfer({10'h2A7, 10'h100}, 2'b01, 1, 16'hEE33, "R2");
    xfer({10'h2A7, 10'h100}, 2'b10, 1, 16'h44DD, "R2");
    xfer({10'h2A7, 10'h100}, 2'b11, 0, 16'h0, "R2 word after byte writes");
    xfer({10'h2A7, 10'h100}, 2'b10, 0, 16'h0, "R2 upper lane read");
    xfer({10'h2A7, 10'h100}, 2'b01, 0, 16'h0, "R2 lower lane read");
    idle(8);
    a0 = cas_fall_cnt;
    xfer({10'h2A7, 10'h100}, 2'b00, 0, 16'h0, "R2 no-lane read");
    idle(8);
    chk(cas_fall_cnt == a0, "R2 no strobe for empty enables", cas_fall_cnt - a0, 0);

    // R8 idle row closes itself
    xfer({10'h111, 10'h011}, 2'b11, 1, 16'h2222, "R8");
    idle(120);
    chk(ras_n, "R8 idle row closed", ras_n, 1);

    // R9 refresh grant
    xfer({10'h0AA, 10'h055}, 2'b11, 1, 16'h9ABC, "R9");
    ref_req = 1;
    for (int i = 0; i < 60 && !ref_gnt; i++) @(negedge clk);
    chk(ref_gnt, "R9 grant raised", ref_gnt, 1);
    chk(ras_n && lcas_n && ucas_n, "R9 strobes released", {ras_n, lcas_n, ucas_n}, 3'b111);
    chk(!req_ready, "R9 host held off", req_ready, 0);
    chk(peek({10'h0AA, 10'h055}) == 16'h9ABC, "R9 access finished first",
        peek({10'h0AA, 10'h055}), 16'h9ABC);
    idle(10);
    chk(ref_gnt && ras_n, "R9 grant held", {ref_gnt, ras_n}, 2'b11);
    ref_req = 0;
    idle(3);
    chk(!ref_gnt && req_ready, "R9 grant dropped", {ref_gnt, req_ready}, 2'b01);
    a0 = act_cnt;
    xfer({10'h0AA, 10'h055}, 2'b11, 0, 16'h0, "R9 read after refresh");
    idle(10);
    chk(act_cnt - a0 == 1, "R9 row reactivated", act_cnt - a0, 1);

    idle(20);
    chk(expq.size() == 0, "R3 all reads returned", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule